// File: doc/BRIEF.md
# Synchronous SRAM with Selectable Read Pipelining

This block is a clocked static RAM array with its command front end. Address, chip enable, write controls and write data are captured on the rising clock edge. A read returns the addressed word either straight from the array (flow-through timing) or through an extra output register (pipelined timing). A level input picks the timing and may change at any time.

Byte-granular writes come from a byte-write enable and one select per lane. A global write stores the whole word whatever the lane controls say. Deselect and write commands turn the read-data enable off with the same latency as a read turns it on, so a deselect reaches the output one cycle after the last read data when pipelined. The output enable and sleep inputs act without waiting for a clock edge. Sleep blanks the output and blocks writes, and the stored data is kept. Burst address generation lives outside this block: the caller presents every address.

Top module: `sync_sram_fpo`

## Requirements
- R1: With `pipe_sel` low, a read command sampled at edge k drives the word stored at its address on `rdata`, with `rdata_oe` high, from just after edge k until edge k+1.
- R2: With `pipe_sel` high, a read command sampled at edge k is shown from just after edge k+1 until edge k+2. The data is the array content as it stood before any write sampled at edge k+1.
- R3: `pipe_sel` acts on the output directly. Changing it selects the other timing from the next sample on, and the stored data is not affected.
- R4: A command with `ce`=1, `gw`=0 and `bw_en`=1 writes only the lanes whose `byte_sel[i]` is 1. Lane i is bits i*9+8 down to i*9 of `wdata`. The other lanes keep their contents.
- R5: A command with `ce`=1 and `gw`=1 writes all four lanes, whatever `bw_en` and `byte_sel` are.
- R6: A command with `ce`=1 is a write when `gw`=1, or when `bw_en`=1 with at least one `byte_sel` bit set. Every other selected command, including `bw_en`=1 with no lane selected, is a read.
- R7: A deselect (`ce`=0) or a write sampled at edge k leaves `rdata_oe` low over the interval where a read sampled at edge k would have been shown.
- R8: `oe`=0 forces `rdata_oe` low at once, with no clock edge needed.
- R9: `sleep`=1 forces `rdata_oe` low at once. A command sampled while `sleep`=1 writes nothing and counts as a deselect. Stored words survive sleep.
- R10: While `rst_n` is low, and after it until a read has been sampled, `rdata_oe` is low.
- R11: `rdata` is all zeros whenever `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output pipeline |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| byte_sel | input | 4 | Per-lane write select, active high |
| bw_en | input | 1 | Byte-write enable |
| gw | input | 1 | Global write, all lanes |
| ce | input | 1 | Chip enable; low is a deselect |
| pipe_sel | input | 1 | 1 = pipelined read timing, 0 = flow-through |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous low-power request |
| rdata | output | 36 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
In pipelined timing the output register shows the word read one cycle earlier during the same cycle in which a new write is sampled. When both target the same address, the register must still hold the old word. The bench writes an address directly after a pipelined read of it, both in a directed step and often in a random run over only sixteen addresses. A behavioural model takes the pipelined value before it applies the current cycle's write, and every cycle the model's enable and data are compared with the design's. A second overlap, a deselect that falls while the last read data is still on the output, is judged by the same per-cycle comparison.

// File: rtl/sync_sram_fpo.sv
module sync_sram_fpo #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        byte_sel,
  input  logic                    bw_en,
  input  logic                    gw,
  input  logic                    ce,
  input  logic                    pipe_sel,
  input  logic                    oe,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] lane_m, pipe_q, flow_d;
  logic [AW-1:0] a_q;
  logic          rd_q, rd_q2;

  wire is_wr  = gw | (bw_en & |byte_sel);
  wire do_wr  = ce & ~sleep & is_wr;
  wire do_rd  = ce & ~sleep & ~is_wr;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_m[i*LANE_W +: LANE_W] = {LANE_W{gw | byte_sel[i]}};
  end

  always_ff @(posedge clk)
    if (do_wr) mem[addr] <= (mem[addr] & ~lane_m) | (wdata & lane_m);

  always_ff @(posedge clk) begin
    a_q    <= addr;
    pipe_q <= mem[a_q];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q  <= 1'b0;
      rd_q2 <= 1'b0;
    end else begin
      rd_q  <= do_rd;
      rd_q2 <= rd_q;
    end

  assign flow_d   = mem[a_q];
  assign rdata_oe = oe & ~sleep & (pipe_sel ? rd_q2 : rd_q);
  assign rdata    = rdata_oe ? (pipe_sel ? pipe_q : flow_d) : '0;
endmodule

module sync_sram_fpo_chk #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [LANES-1:0]        byte_sel,
  input logic                    bw_en,
  input logic                    gw,
  input logic                    ce,
  input logic                    pipe_sel,
  input logic                    oe,
  input logic                    sleep,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic                    rdata_oe
);
  logic [1:0] since;
  wire live   = (since == 2'd2);
  wire rd_cmd = ce & ~sleep & ~(gw | (bw_en & |byte_sel));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since <= '0;
    else if (since != 2'd2) since <= since + 2'd1;

  AST_FLOW_ON:  assert property (@(posedge clk) disable iff (!rst_n)
    (live && !pipe_sel && oe && !sleep && $past(rd_cmd)) |-> rdata_oe);      // R1
  AST_PIPE_ON:  assert property (@(posedge clk) disable iff (!rst_n)
    (live && pipe_sel && oe && !sleep && $past(rd_cmd, 2)) |-> rdata_oe);    // R2
  AST_FLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !pipe_sel && !$past(rd_cmd)) |-> !rdata_oe);                    // R7
  AST_PIPE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (live && pipe_sel && !$past(rd_cmd, 2)) |-> !rdata_oe);                  // R7
  AST_OE_GATE:  assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rdata_oe);                                                      // R8
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_oe);                                                    // R9
  AST_IN_RESET: assert property (@(posedge clk)
    !rst_n |-> !rdata_oe);                                                   // R10
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> (rdata == '0));                                            // R11
endmodule

bind sync_sram_fpo sync_sram_fpo_chk #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_sel(byte_sel), .bw_en(bw_en), .gw(gw),
  .ce(ce), .pipe_sel(pipe_sel), .oe(oe), .sleep(sleep),
  .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/sync_sram_fpo_bench.sv
`timescale 1ns/1ps
module sync_sram_fpo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [7:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic [3:0]  byte_sel = '0;
  logic        bw_en = 1'b0, gw = 1'b0, ce = 1'b0, pipe_sel = 1'b1;
  logic        oe = 1'b1, sleep = 1'b0;
  logic [35:0] rdata;
  logic        rdata_oe;

  int checks = 0, fails = 0;
  logic [35:0] ref_mem [256];
  bit          h_rd [$];
  logic [7:0]  h_addr [$];
  logic [35:0] h_pd [$];

  always #2.5 clk = ~clk;

  sync_sram_fpo u_sync_sram_fpo (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .byte_sel(byte_sel),
    .bw_en(bw_en), .gw(gw), .ce(ce), .pipe_sel(pipe_sel), .oe(oe),
    .sleep(sleep), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    bit wr, rd, vld;
    logic [35:0] ed;
    int n;
    @(posedge clk);
    if (h_addr.size() > 0) h_pd[h_pd.size()-1] = ref_mem[h_addr[h_addr.size()-1]];
    wr = ce && !sleep && (gw || (bw_en && byte_sel != 0));
    rd = ce && !sleep && !wr;
    if (wr)
      for (int i = 0; i < 4; i++)
        if (gw || byte_sel[i]) ref_mem[addr][i*9 +: 9] = wdata[i*9 +: 9];
    h_rd.push_back(rd); h_addr.push_back(addr); h_pd.push_back('0);
    if (h_rd.size() > 3) begin
      void'(h_rd.pop_front()); void'(h_addr.pop_front()); void'(h_pd.pop_front());
    end
    @(negedge clk);
    n = h_rd.size();
    if (pipe_sel) begin
      vld = (n >= 2) && h_rd[n-2];
      ed  = (n >= 2) ? h_pd[n-2] : '0;
    end else begin
      vld = h_rd[n-1];
      ed  = ref_mem[h_addr[n-1]];
    end
    vld = vld && oe && !sleep;
    if (!vld) ed = '0;
    if (tag == "") tag = sleep ? "R9" : !oe ? "R8" : !vld ? "R7" : pipe_sel ? "R2" : "R1";
    chk({tag, " enable"}, {35'd0, rdata_oe}, {35'd0, vld});
    chk({tag, " data"}, rdata, ed);
  endtask

  task automatic cmd(input bit c, input int a, input logic [35:0] d,
                     input logic [3:0] bs, input bit b, input bit g);
    ce = c; addr = a[7:0]; wdata = d; byte_sel = bs; bw_en = b; gw = g;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    cmd(1, 1, '0, 4'h0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 enable in reset", {35'd0, rdata_oe}, 36'd0);
    rst_n = 1'b1;
    cmd(0, 0, '0, 0, 0, 0);
    @(negedge clk);
    chk("R10 enable after reset", {35'd0, rdata_oe}, 36'd0);
    for (int a = 0; a < 16; a++) begin
      cmd(1, a, 36'h0A5A5A5A5 + a * 36'h010203041, 4'h0, 0, 1);
      step("R10");
    end
    // R2 pipelined read of 3, then deselects (R7: turns off one cycle later)
    pipe_sel = 1; cmd(1, 3, '0, 0, 0, 0); step("R2");
    cmd(0, 0, '0, 0, 0, 0); step("R2");
    step("R7"); step("R7");
    // R4 byte write lanes 0 and 2 of address 4
    cmd(1, 4, 36'hFFFFFFFFF, 4'b0101, 1, 0); step("R4");
    cmd(1, 4, '0, 0, 0, 0); step("R4"); cmd(0, 0, '0, 0, 0, 0); step("R4");
    // R5 global write ignores lane controls
    cmd(1, 5, 36'h123456789, 4'b0000, 0, 1); step("R5");
    // R6 bw_en with no lanes is a read; flow-through (R1)
    pipe_sel = 0;
    cmd(1, 5, 36'h0, 4'b0000, 1, 0); step("R6");
    cmd(1, 4, '0, 0, 0, 0); step("R1");
    // pipelined read then same-address write next cycle
    pipe_sel = 1;
    cmd(1, 7, '0, 0, 0, 0); step("R2");
    cmd(1, 7, 36'h0FEDCBA98, 0, 0, 1); step("R2");
    cmd(1, 7, '0, 0, 0, 0); step("R7"); cmd(0, 0, '0, 0, 0, 0); step("R2");
    // R9 sleep: write ignored, output off, data kept
    sleep = 1; cmd(1, 6, 36'h0, 0, 0, 1); step("R9");
    cmd(1, 6, '0, 0, 0, 0); step("R9");
    sleep = 0; cmd(1, 6, '0, 0, 0, 0); step("R9");
    cmd(0, 0, '0, 0, 0, 0); step("R9");
    // R8 asynchronous oe drop, R9 asynchronous sleep, R11 zero data
    pipe_sel = 0; cmd(1, 2, '0, 0, 0, 0); step("R1");
    oe = 0; #1;
    chk("R8 async enable", {35'd0, rdata_oe}, 36'd0);
    chk("R11 idle data", rdata, 36'd0);
    oe = 1; #1;
    chk("R8 enable restored", {35'd0, rdata_oe}, 36'd1);
    sleep = 1; #1;
    chk("R9 async enable", {35'd0, rdata_oe}, 36'd0);
    sleep = 0;
    // R3 mode switch on a live read stream
    cmd(1, 8, '0, 0, 0, 0); step("R3");
    pipe_sel = 1; cmd(1, 9, '0, 0, 0, 0); step("R3");
    pipe_sel = 0; step("R3");
    // random mix
    void'($urandom(32'd77));
    for (int c = 0; c < 1500; c++) begin
      int r;
      r = $urandom % 100;
      if (c % 53 == 0) pipe_sel = $urandom % 2;
      oe = ($urandom % 10) != 0;
      sleep = ($urandom % 30) == 0;
      cmd(r < 85, $urandom % 16, {$urandom, $urandom} , $urandom % 16,
          (r % 5) == 1, (r % 5) == 2);
      step("");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule